// File: doc/BRIEF.md
# Dual-Clock Show-Ahead Queue

This block moves data words from one clock domain to another, unrelated one, keeping their order. A producer on the write clock offers a word by raising a trigger. The word is taken on a write-clock edge only when the block also reports a free slot. A consumer on the read clock always sees the oldest stored word on the data output. It takes that word by raising its own trigger while the block reports data present. Both clocks may run near 100 MHz at unrelated rates.

Storage is a power-of-two array with one write port and one read port, so both domains work at the same time. Each side keeps a pointer one bit wider than the address. That pointer is sent to the other domain in Gray code through a two-stage synchronizer. One active-low reset clears both domains at once. It takes effect at once, and each domain leaves reset on its own clock edge.

Top module: `xclk_queue`

## Requirements
- R1: While reset is low and after it is released, wr_rdy_o is 1 and rd_rdy_o is 0 (queue empty).
- R2: Words leave the read side in the same order and with the same values as they were accepted on the write side, one word per accepted handshake.
- R3: A word is accepted on a wr_clk_i rising edge only when wr_trig_i and wr_rdy_o are both 1. A trigger while wr_rdy_o is 0 is ignored, and no stored word is overwritten.
- R4: A word is removed on a rd_clk_i rising edge only when rd_trig_i and rd_rdy_o are both 1. A trigger while rd_rdy_o is 0 is ignored, and no word is removed or repeated.
- R5: With no reads, exactly DEPTH words are accepted, and then wr_rdy_o goes to 0.
- R6: rd_rdy_o goes to 1 within a few read-clock cycles after a word is accepted, and returns to 0 once every stored word has been removed.
- R7: While rd_rdy_o is 1, rd_data_o holds the oldest stored word and stays stable until that word is removed.
- R8: Pulling rst_ni low empties the queue in both domains. Words accepted before reset never appear after it.
- R9: Each cross-domain pointer changes in at most one bit per cycle of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write-domain clock |
| rd_clk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| wr_trig_i | input | 1 | Request to store wr_data_i |
| wr_data_i | input | WIDTH | Word to store |
| wr_rdy_o | output | 1 | At least one slot free |
| rd_trig_i | input | 1 | Request to remove the front word |
| rd_data_o | output | WIDTH | Oldest stored word (show-ahead) |
| rd_rdy_o | output | 1 | At least one word stored; rd_data_o valid |

## Verification
The assertions assume that each trigger and data input changes only away from its own clock's rising edge. They also assume that rst_ni is held low for at least one edge of each clock. The bench drives every input on the falling edge of the clock that samples it, and holds reset across several edges of both clocks. The two clocks run at unrelated periods, so pointer crossings land at varying phases. The stimulus deliberately holds triggers high against full and empty states.

// File: rtl/xq_pkg.sv
package xq_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] bin);
    return bin ^ (bin >> 1);
  endfunction
endpackage

// File: rtl/xq_rst_sync.sv
module xq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  // assert asynchronously, release on clk_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/xq_sync.sv
module xq_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage <= '0;
    else begin
      stage[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q_o = stage[STAGES-1];
endmodule

// File: rtl/xq_ptr_ctrl.sv
module xq_ptr_ctrl #(
  parameter int unsigned DEPTH    = 256,
  parameter bit          IS_WRITE = 1'b1,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned PW      = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [PW-1:0] far_gray_i,
  output logic          rdy_o,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic [PW-1:0] gray_o
);
  import xq_pkg::*;

  logic [PW-1:0] bin_q, bin_nxt;
  logic [31:0]   gray_wide;

  generate
    if (IS_WRITE) begin : g_full
      assign rdy_o = (gray_o != {~far_gray_i[PW-1:PW-2], far_gray_i[PW-3:0]});
    end else begin : g_empty
      assign rdy_o = (gray_o != far_gray_i);
    end
  endgenerate

  assign fire_o    = trig_i & rdy_o;
  assign bin_nxt   = bin_q + PW'(fire_o);
  assign gray_wide = bin_to_gray(32'(bin_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_o <= gray_wide[PW-1:0];
    end
  end

  assign addr_o = bin_q[AW-1:0];

  // pointer frozen when the side is not ready (R3 write, R4 read)
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_WRITE && !rdy_o) |=> $stable(gray_o));
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_WRITE && !rdy_o) |=> $stable(gray_o));
  assert_gray_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/xq_mem.sv
module xq_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             wr_clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // unregistered read gives show-ahead output
  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/xclk_queue.sv
module xclk_queue #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             wr_clk_i,
  input  logic             rd_clk_i,
  input  logic             rst_ni,
  input  logic             wr_trig_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             wr_rdy_o,
  input  logic             rd_trig_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_rdy_o
);
  import xq_pkg::*;

  logic          wr_rst_n, rd_rst_n;
  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_at_rd, rd_gray_at_wr;

  xq_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .rst_no(wr_rst_n));
  xq_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .rst_no(rd_rst_n));

  xq_ptr_ctrl #(.DEPTH(DEPTH), .IS_WRITE(1'b1)) u_wr_ctrl (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_n), .trig_i(wr_trig_i),
    .far_gray_i(rd_gray_at_wr), .rdy_o(wr_rdy_o), .fire_o(wr_fire),
    .addr_o(wr_addr), .gray_o(wr_gray));

  xq_ptr_ctrl #(.DEPTH(DEPTH), .IS_WRITE(1'b0)) u_rd_ctrl (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_n), .trig_i(rd_trig_i),
    .far_gray_i(wr_gray_at_rd), .rdy_o(rd_rdy_o), .fire_o(rd_fire),
    .addr_o(rd_addr), .gray_o(rd_gray));

  xq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_n), .d_i(wr_gray), .q_o(wr_gray_at_rd));
  xq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_n), .d_i(rd_gray), .q_o(rd_gray_at_wr));

  xq_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .wr_clk_i(wr_clk_i), .wr_en_i(wr_fire), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o));

  // front word held until popped
  assert_show_ahead_hold_R7: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_n)
    (rd_rdy_o && !rd_trig_i) |=> (rd_rdy_o && $stable(rd_data_o)));
  // reset state in each domain
  assert_reset_empty_R1: assert property (@(posedge rd_clk_i)
    !rd_rst_n |-> !rd_rdy_o);
  assert_reset_free_R1: assert property (@(posedge wr_clk_i)
    !wr_rst_n |-> wr_rdy_o);
endmodule

// File: tb/xclk_queue_tb_top.sv
`timescale 1ns/1ps
module xclk_queue_tb_top;
  localparam int DEPTH = 256;
  localparam int WIDTH = 16;

  logic wr_clk = 0, rd_clk = 0, rst_ni = 0;
  logic wr_trig = 0, rd_trig = 0;
  logic [WIDTH-1:0] wr_data = '0;
  logic wr_rdy, rd_rdy;
  logic [WIDTH-1:0] rd_data;

  int checks = 0, errors = 0;
  bit pop_en = 0;
  int popped = 0;
  logic [WIDTH-1:0] exp_q[$];

  always #5     wr_clk = ~wr_clk;   // 100 MHz
  always #4.63  rd_clk = ~rd_clk;   // ~108 MHz

  xclk_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_trig_i(wr_trig), .wr_data_i(wr_data), .wr_rdy_o(wr_rdy),
    .rd_trig_i(rd_trig), .rd_data_o(rd_data), .rd_rdy_o(rd_rdy));

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops and compares the front word
  always @(negedge rd_clk) begin
    if (pop_en && rst_ni && rd_rdy) begin
      if (exp_q.size() == 0) check(0, "R4 pop with nothing expected", 32'(rd_data), 0);
      else begin
        logic [WIDTH-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R2 data order", 32'(rd_data), 32'(e));
      end
      popped++;
      rd_trig = 1;
    end else begin
      rd_trig = pop_en;  // keeps trigger high against an empty queue (R4)
    end
  end

  // driver: pushes one word, waits for a free slot
  task automatic push_word(input logic [WIDTH-1:0] d);
    @(negedge wr_clk);
    while (!wr_rdy) @(negedge wr_clk);
    wr_trig = 1;
    wr_data = d;
    exp_q.push_back(d);
    @(negedge wr_clk);
    wr_trig = 0;
  endtask

  task automatic wait_rd_idle(input int max_cyc);
    for (int i = 0; i < max_cyc && (exp_q.size() != 0 || rd_rdy); i++) @(negedge rd_clk);
  endtask

  initial begin
    #1_500_000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (2) @(negedge wr_clk);
    check(wr_rdy == 1, "R1 wr_rdy in reset", 32'(wr_rdy), 1);
    check(rd_rdy == 0, "R1 rd_rdy in reset", 32'(rd_rdy), 0);
    repeat (3) @(negedge rd_clk);
    rst_ni = 1;
    repeat (5) @(negedge wr_clk);
    check(wr_rdy == 1, "R1 wr_rdy after reset", 32'(wr_rdy), 1);
    check(rd_rdy == 0, "R1 rd_rdy after reset", 32'(rd_rdy), 0);

    // R7/R6: single word shows ahead and holds
    push_word(16'hA5C3);
    n = 0;
    while (!rd_rdy && n < 10) begin @(negedge rd_clk); n++; end
    check(rd_rdy == 1 && n < 10, "R6 rd_rdy rises", 32'(n), 5);
    check(rd_data == 16'hA5C3, "R7 front word", 32'(rd_data), 32'hA5C3);
    repeat (6) @(negedge rd_clk);
    check(rd_data == 16'hA5C3 && rd_rdy, "R7 front word held", 32'(rd_data), 32'hA5C3);

    // R2: streaming with reader on
    pop_en = 1;
    for (int i = 0; i < 60; i++) push_word(WIDTH'(i * 37 + 5));
    wait_rd_idle(2000);
    repeat (6) @(negedge rd_clk);
    check(exp_q.size() == 0, "R2 all words delivered", 32'(exp_q.size()), 0);
    check(rd_rdy == 0, "R6 rd_rdy falls when empty", 32'(rd_rdy), 0);

    // R4: trigger held against empty queue, then a few words
    repeat (20) @(negedge rd_clk);
    popped = 0;
    for (int i = 0; i < 3; i++) push_word(WIDTH'(16'h7000 + i));
    wait_rd_idle(500);
    repeat (6) @(negedge rd_clk);
    check(popped == 3, "R4 no extra pops from empty", 32'(popped), 3);

    // R5: fill with reader off
    pop_en = 0;
    @(negedge rd_clk);
    n = 0;
    for (int i = 0; i < DEPTH + 8; i++) begin
      @(negedge wr_clk);
      if (wr_rdy) begin
        wr_trig = 1; wr_data = WIDTH'(16'h1000 + i);
        exp_q.push_back(wr_data); n++;
      end else wr_trig = 0;
    end
    wr_trig = 0;
    check(n == DEPTH, "R5 accepted count at full", 32'(n), DEPTH);
    @(negedge wr_clk);
    check(wr_rdy == 0, "R5 wr_rdy low at full", 32'(wr_rdy), 0);

    // R3: hammer while full, data must not land
    for (int i = 0; i < 10; i++) begin
      @(negedge wr_clk);
      wr_trig = 1; wr_data = 16'hDEAD;
    end
    @(negedge wr_clk);
    wr_trig = 0;
    check(wr_rdy == 0, "R3 still full after ignored triggers", 32'(wr_rdy), 0);
    popped = 0;
    pop_en = 1;
    wait_rd_idle(5000);
    repeat (6) @(negedge rd_clk);
    check(popped == DEPTH, "R3 no overwrite, drained count", 32'(popped), DEPTH);
    repeat (6) @(negedge wr_clk);
    check(wr_rdy == 1, "R6 wr_rdy back after drain", 32'(wr_rdy), 1);

    // R8: reset with stored words
    pop_en = 0;
    @(negedge rd_clk);
    for (int i = 0; i < 5; i++) push_word(WIDTH'(16'hBEE0 + i));
    repeat (6) @(negedge rd_clk);
    check(rd_rdy == 1, "R8 words stored before reset", 32'(rd_rdy), 1);
    rst_ni = 0;
    exp_q.delete();
    #1;
    check(rd_rdy == 0, "R8 rd_rdy cleared by reset", 32'(rd_rdy), 0);
    repeat (3) @(negedge rd_clk);
    rst_ni = 1;
    repeat (6) @(negedge rd_clk);
    check(rd_rdy == 0 && wr_rdy == 1, "R8 empty after reset", {rd_rdy, wr_rdy}, 2'b01);
    pop_en = 1;
    push_word(16'h0042);
    wait_rd_idle(500);
    repeat (4) @(negedge rd_clk);
    check(exp_q.size() == 0, "R8 only new word seen", 32'(exp_q.size()), 0);

    finish_run();
  end
endmodule